// File: doc/BRIEF.md
# I2C Register-Access Target with Transmit Backpressure

This block is an I2C target that gives a host read and write access to a register file next to it. SCL and SDA are oversampled by a fast system clock. The block detects START, repeated START and STOP on the bus. It matches a 7-bit target address and latches a register sub-address. It then moves data bytes into or out of the selected register. Two sub-addresses are special. One is the push port of a transmit FIFO and the other is the pop port of a receive FIFO. Consecutive data bytes in one transaction all go to the same sub-address, so a host can stream bytes into or out of either FIFO.

Writes to the transmit port are refused while the FIFO reports full. The block leaves SDA released during that byte's acknowledge clock and drops the byte. To read, the host first writes the target address and the sub-address. It then issues a repeated START and the target address with the read bit set, and clocks data out until it answers a byte with NACK. SDA is driven only as an open-drain pull-down, and it changes only while SCL is low. The system clock must run at least 16 times faster than SCL, which covers both the 100 kbit/s and 400 kbit/s bus rates.

Top module: `i2c_reg_target`

## Requirements
- R1: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START at any point, including in the middle of a transaction, restarts address reception. A STOP returns the block to idle with SDA released.
- R2: The first byte after a START is taken MSB first as a 7-bit address plus a read/write bit in bit 0, where 1 means read. When the address equals TARGET_ADDR, the block pulls SDA low for the acknowledge clock.
- R3: When the address does not match, the block never pulls SDA low and issues no write or pop strobe. It ignores all traffic until the next START or STOP.
- R4: In a write transaction, the byte after the address is latched as the sub-address, shown on reg_sub_o, and acknowledged.
- R5: Each accepted data byte is acknowledged. One system cycle after the falling SCL edge that ends its acknowledge clock is seen, reg_wr_o pulses for exactly one cycle, with the byte on reg_wdata_o.
- R6: A data byte aimed at sub-address TX_PORT while tx_full_i is high gets no acknowledge (SDA stays released), and no reg_wr_o pulse is issued for it.
- R7: Every data byte in one transaction targets the same latched sub-address. No auto-increment takes place.
- R8: After a write of address plus sub-address, a repeated START and the address with the read bit set, the block shifts out reg_rdata_i for that sub-address MSB first. It loads a new byte after each host acknowledge.
- R9: Each time a byte is loaded for a read of sub-address RX_PORT, rx_pop_o pulses for one cycle. Reads of any other sub-address never pulse rx_pop_o.
- R10: A host NACK on a read byte ends the transfer. Further SCL clocks read back released SDA (all ones) and cause no load and no pop.
- R11: sda_oe_o, where 1 means pull SDA low, only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_sub_o | output | SUB_W | Latched register sub-address |
| reg_wdata_o | output | 8 | Write data for the register file |
| reg_wr_o | output | 1 | One-cycle write/push strobe |
| reg_rdata_i | input | 8 | Read data of the register at reg_sub_o |
| tx_full_i | input | 1 | Transmit FIFO full |
| rx_pop_o | output | 1 | One-cycle receive FIFO pop strobe |

## Verification
The assertions check four things on every cycle. SDA drive changes only while SCL is low, the write and pop strobes last one cycle and never coincide, no write reaches the transmit port while it is full, and pops happen only with the receive port selected. The bench scenarios are the only way to show the bus-level results. These are the acknowledge or refusal seen by the host, the data bytes and sub-addresses that arrive, MSB-first read data across a repeated START, the silence after an address mismatch, and the end of a read after a host NACK.

// File: rtl/i2c_reg_target_pkg.sv
package i2c_reg_target_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_IGNORE
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '1;
    else     chain[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_reg_target_pkg::*;
#(
  parameter int          ADDR_W      = 7,
  parameter int          SUB_W       = 8,
  parameter logic [6:0]  TARGET_ADDR = 7'h2A,
  parameter logic [7:0]  TX_PORT     = 8'h00,
  parameter logic [7:0]  RX_PORT     = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rdata,
  input  logic              tx_full,
  output logic              sda_oe,
  output logic [SUB_W-1:0]  sub_addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              wr_stb,
  output logic              pop_stb
);
  localparam logic [BIT_CNT_W-1:0] BITS_FULL = BIT_CNT_W'(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] LAST_OUT  = BIT_CNT_W'(BYTE_W - 1);

  tgt_state_t               state;
  logic [BYTE_W-1:0]        shreg;
  logic [BIT_CNT_W-1:0]     bitcnt;
  logic                     rd_mode;
  logic                     refuse;
  logic                     host_ack;

  logic addr_hit;
  logic tx_blocked;
  logic rx_sel;

  assign addr_hit   = (shreg[BYTE_W-1 -: ADDR_W] == TARGET_ADDR);
  assign tx_blocked = (sub_addr == SUB_W'(TX_PORT)) && tx_full;
  assign rx_sel     = (sub_addr == SUB_W'(RX_PORT));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      rd_mode  <= 1'b0;
      refuse   <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      sub_addr <= '0;
      wdata    <= '0;
      wr_stb   <= 1'b0;
      pop_stb  <= 1'b0;
    end else begin
      wr_stb  <= 1'b0;
      pop_stb <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise && bitcnt != BITS_FULL) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == BITS_FULL) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe  <= 1'b1;
                  rd_mode <= shreg[0];
                  state   <= ST_ADDR_ACK;
                end else begin
                  state   <= ST_IGNORE;
                end
              end else if (state == ST_SUB) begin
                sub_addr <= shreg[SUB_W-1:0];
                sda_oe   <= 1'b1;
                state    <= ST_SUB_ACK;
              end else begin
                if (tx_blocked) begin
                  refuse <= 1'b1;
                end else begin
                  refuse <= 1'b0;
                  wdata  <= shreg;
                  sda_oe <= 1'b1;
                end
                state <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                shreg   <= rdata;
                sda_oe  <= ~rdata[BYTE_W-1];
                bitcnt  <= '0;
                pop_stb <= rx_sel;
                state   <= ST_RDATA;
              end else begin
                sda_oe  <= 1'b0;
                state   <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              wr_stb <= ~refuse;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bitcnt == LAST_OUT) begin
                sda_oe <= 1'b0;
                state  <= ST_RDATA_ACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                shreg   <= rdata;
                sda_oe  <= ~rdata[BYTE_W-1];
                bitcnt  <= '0;
                pop_stb <= rx_sel;
                state   <= ST_RDATA;
              end else begin
                state   <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_target_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         SUB_W       = 8,
  parameter logic [6:0] TARGET_ADDR = 7'h2A,
  parameter logic [7:0] TX_PORT     = 8'h00,
  parameter logic [7:0] RX_PORT     = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [SUB_W-1:0] reg_sub_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_wr_o,
  input  logic [7:0]       reg_rdata_i,
  input  logic             tx_full_i,
  output logic             rx_pop_o
);
  logic [1:0] lines_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_i, sda_i}),
    .dout (lines_s)
  );

  i2c_cond_detect u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (lines_s[1]),
    .sda_s     (lines_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_ctrl #(
    .ADDR_W      (7),
    .SUB_W       (SUB_W),
    .TARGET_ADDR (TARGET_ADDR),
    .TX_PORT     (TX_PORT),
    .RX_PORT     (RX_PORT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (lines_s[0]),
    .rdata     (reg_rdata_i),
    .tx_full   (tx_full_i),
    .sda_oe    (sda_oe_o),
    .sub_addr  (reg_sub_o),
    .wdata     (reg_wdata_o),
    .wr_stb    (reg_wr_o),
    .pop_stb   (rx_pop_o)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int         SUB_W   = 8,
  parameter logic [7:0] TX_PORT = 8'h00,
  parameter logic [7:0] RX_PORT = 8'h01
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic [SUB_W-1:0] reg_sub_o,
  input logic             reg_wr_o,
  input logic             tx_full_i,
  input logic             rx_pop_o
);
  p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  p_wr_single_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o);

  p_no_push_when_full_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_o && reg_sub_o == SUB_W'(TX_PORT)) |-> !tx_full_i);

  p_pop_single_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    rx_pop_o |=> !rx_pop_o);

  p_pop_only_rx_port_r9: assert property (@(posedge clk) disable iff (rst)
    rx_pop_o |-> reg_sub_o == SUB_W'(RX_PORT));

  p_wr_pop_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_o && rx_pop_o));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(
  .SUB_W   (SUB_W),
  .TX_PORT (TX_PORT),
  .RX_PORT (RX_PORT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .reg_sub_o (reg_sub_o),
  .reg_wr_o  (reg_wr_o),
  .tx_full_i (tx_full_i),
  .rx_pop_o  (rx_pop_o)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam logic [6:0] TGT = 7'h2A;
  localparam logic [7:0] TXP = 8'h00;
  localparam logic [7:0] RXP = 8'h01;
  localparam int Q = 10;
  localparam int TX_DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda;
  logic sda_oe;
  logic [7:0] reg_sub, wdata, rdata;
  logic reg_wr, rx_pop, tx_full;

  always #2 clk = ~clk;

  assign sda = ~(host_low | sda_oe);

  i2c_reg_target #(.TARGET_ADDR(TGT), .TX_PORT(TXP), .RX_PORT(RXP)) dut (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl),
    .sda_i       (sda),
    .sda_oe_o    (sda_oe),
    .reg_sub_o   (reg_sub),
    .reg_wdata_o (wdata),
    .reg_wr_o    (reg_wr),
    .reg_rdata_i (rdata),
    .tx_full_i   (tx_full),
    .rx_pop_o    (rx_pop)
  );

  logic [7:0] regs [0:255];
  logic [7:0] rx_mem [0:7];
  logic [2:0] rx_head = '0;
  int tx_count = 0;
  int wr_n = 0;
  int pop_n = 0;
  int oe_seen = 0;
  logic [7:0] log_sub [0:31];
  logic [7:0] log_dat [0:31];
  int tests = 0;
  int fails = 0;
  bit done = 0;

  assign tx_full = (tx_count >= TX_DEPTH);
  assign rdata = (reg_sub == RXP) ? rx_mem[rx_head] : regs[reg_sub];

  always @(posedge clk) begin
    if (!rst) begin
      if (reg_wr) begin
        if (wr_n < 32) begin
          log_sub[wr_n] = reg_sub;
          log_dat[wr_n] = wdata;
        end
        wr_n++;
        regs[reg_sub] = wdata;
        if (reg_sub == TXP) tx_count++;
      end
      if (rx_pop) begin
        rx_head = rx_head + 3'd1;
        pop_n++;
      end
      if (sda_oe) oe_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    host_low = 1'b0; tick(Q);
    scl = 1'b1;      tick(Q);
    host_low = 1'b1; tick(Q);
    scl = 1'b0;      tick(Q);
  endtask

  task automatic bus_stop;
    host_low = 1'b1; tick(Q);
    scl = 1'b1;      tick(Q);
    host_low = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; tick(Q);
      scl = 1'b1;       tick(2*Q);
      scl = 1'b0;       tick(Q);
    end
    host_low = 1'b0; tick(Q);
    scl = 1'b1;      tick(Q);
    acked = ~sda;    tick(Q);
    scl = 1'b0;      tick(Q);
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] b, output bit glitch);
    glitch = 0;
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda; tick(Q - 1);
      if (sda != b[i]) glitch = 1;
      tick(1);
      scl = 1'b0; tick(Q);
    end
    host_low = ack_it; tick(Q);
    scl = 1'b1;        tick(2*Q);
    scl = 1'b0;        tick(Q);
    host_low = 1'b0;
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", int'(sda_oe), 0);
    chk(reg_wr == 1'b0, "R5", "reg_wr after reset", int'(reg_wr), 0);
    chk(rx_pop == 1'b0, "R9", "rx_pop after reset", int'(rx_pop), 0);
  endtask

  task automatic t_write_single;
    bit a0, a1, a2;
    int w0 = wr_n;
    bus_start();
    send_byte({TGT, 1'b0}, a0);
    send_byte(8'h03, a1);
    chk(reg_sub == 8'h03, "R4", "latched sub-address", reg_sub, 8'h03);
    send_byte(8'hA5, a2);
    bus_stop();
    chk(a0, "R2", "address ack", a0, 1);
    chk(a1, "R4", "sub-address ack", a1, 1);
    chk(a2, "R5", "data ack", a2, 1);
    chk(wr_n == w0 + 1, "R5", "write count", wr_n - w0, 1);
    chk(log_dat[w0] == 8'hA5 && log_sub[w0] == 8'h03, "R5", "write data",
        {log_sub[w0], log_dat[w0]}, 16'h03A5);
    chk(sda_oe == 1'b0, "R1", "released after stop", int'(sda_oe), 0);
  endtask

  task automatic t_write_stream;
    bit a;
    int w0 = wr_n;
    logic [7:0] vals [3] = '{8'h11, 8'h22, 8'h33};
    bus_start();
    send_byte({TGT, 1'b0}, a);
    send_byte(8'h05, a);
    foreach (vals[k]) send_byte(vals[k], a);
    bus_stop();
    chk(wr_n == w0 + 3, "R7", "stream write count", wr_n - w0, 3);
    for (int k = 0; k < 3; k++)
      chk(log_sub[w0+k] == 8'h05 && log_dat[w0+k] == vals[k], "R7", "stream byte",
          {log_sub[w0+k], log_dat[w0+k]}, {8'h05, vals[k]});
  endtask

  task automatic t_read_reg;
    bit a, g;
    logic [7:0] b;
    int p0 = pop_n;
    bus_start();
    send_byte({TGT, 1'b0}, a);
    send_byte(8'h03, a);
    bus_start();
    send_byte({TGT, 1'b1}, a);
    chk(a, "R2", "read address ack", a, 1);
    recv_byte(1'b0, b, g);
    bus_stop();
    chk(b == 8'hA5, "R8", "register read", b, 8'hA5);
    chk(!g, "R11", "SDA steady while SCL high", g, 0);
    chk(pop_n == p0, "R9", "no pop for plain register", pop_n - p0, 0);
  endtask

  task automatic t_addr_mismatch;
    bit a0, a1;
    int w0 = wr_n;
    int p0 = pop_n;
    oe_seen = 0;
    bus_start();
    send_byte({7'h15, 1'b0}, a0);
    send_byte(8'h07, a1);
    send_byte(8'h99, a1);
    bus_stop();
    chk(!a0, "R3", "no ack on foreign address", a0, 0);
    chk(oe_seen == 0, "R3", "SDA never pulled", oe_seen, 0);
    chk(wr_n == w0 && pop_n == p0, "R3", "no strobes", wr_n - w0, 0);
    chk(reg_sub == 8'h03, "R3", "sub-address untouched", reg_sub, 8'h03);
  endtask

  task automatic t_tx_full;
    bit a;
    bit acks [6];
    int w0 = wr_n;
    bus_start();
    send_byte({TGT, 1'b0}, a);
    send_byte(TXP, a);
    for (int k = 0; k < 6; k++) send_byte(8'h40 + 8'(k), acks[k]);
    bus_stop();
    for (int k = 0; k < 6; k++)
      chk(acks[k] == (k < TX_DEPTH), "R6", "tx ack pattern", acks[k], k < TX_DEPTH);
    chk(tx_count == TX_DEPTH, "R6", "pushed bytes", tx_count, TX_DEPTH);
    chk(wr_n == w0 + TX_DEPTH, "R6", "write strobes", wr_n - w0, TX_DEPTH);
    chk(log_dat[w0+3] == 8'h43, "R6", "last accepted byte", log_dat[w0+3], 8'h43);
  endtask

  task automatic t_rx_stream;
    bit a, g;
    logic [7:0] b;
    logic [7:0] exp [3] = '{8'hC1, 8'h5E, 8'h80};
    int p0 = pop_n;
    bus_start();
    send_byte({TGT, 1'b0}, a);
    send_byte(RXP, a);
    bus_start();
    send_byte({TGT, 1'b1}, a);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k < 2, b, g);
      chk(b == exp[k], "R8", "rx stream byte", b, exp[k]);
    end
    chk(pop_n == p0 + 3, "R9", "pop count", pop_n - p0, 3);
    recv_byte(1'b0, b, g);
    chk(b == 8'hFF, "R10", "released after host NACK", b, 8'hFF);
    chk(pop_n == p0 + 3, "R10", "no pop after NACK", pop_n - p0, 3);
    bus_stop();
  endtask

  task automatic t_restart_redirect;
    bit a;
    int w0 = wr_n;
    bus_start();
    send_byte({TGT, 1'b0}, a);
    send_byte(8'h07, a);
    bus_start();
    send_byte({TGT, 1'b0}, a);
    send_byte(8'h08, a);
    send_byte(8'h09, a);
    bus_stop();
    chk(wr_n == w0 + 1, "R1", "one write after restart", wr_n - w0, 1);
    chk(log_sub[w0] == 8'h08 && log_dat[w0] == 8'h09, "R1", "restart target",
        {log_sub[w0], log_dat[w0]}, 16'h0809);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 8'(i);
    rx_mem[0] = 8'hC1; rx_mem[1] = 8'h5E; rx_mem[2] = 8'h80;
    for (int i = 3; i < 8; i++) rx_mem[i] = 8'h00;
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_write_single();
    t_write_stream();
    t_read_reg();
    t_addr_mismatch();
    t_tx_full();
    t_rx_stream();
    t_restart_redirect();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule